// File: doc/BRIEF.md
# Procedure-Call Register Window Stack Controller

This controller hands out register windows on procedure calls and takes them back on returns. A pool of 64 windows is tracked as a bitmap. Two windows are directly addressable: the callee's current window and the caller's previous window. A CALL takes the lowest-numbered free window and makes it current, and the previous current window becomes the previous one. A RETURN gives the current window back to the pool and makes the previous window current again.

Callers that have been suspended are not kept in a dedicated hardware stack. Each one is stored as a packed 32-bit word in an ordinary register window called a map window. The controller writes these words through a register-file write port and reads them back through a read port whose data arrives one cycle after the request. A map window holds up to fifteen records. When it is full, a fresh map window is taken from the pool and chained back to the older one through its link word.

When a window is needed and the pool is empty, the controller raises a spill request. It then holds off new commands until an external memory agent acknowledges and names the window it has freed. Moving data to and from memory is left to that agent.

Top module: `winstk_ctrl`

## Requirements
- R1: After reset the current and previous window ids are 0, the map window id is 1, windows 2 to 63 are free, `req_ready` is high, and `spill_req`, `cmd_done`, `ret_ra_valid` and `ret_underflow` are low.
- R2: A CALL takes the lowest-numbered free window. In the cycle `cmd_done` pulses, that window is on `cur_win`, the former current id is on `old_win`, and `ret_ra_valid` is low.
- R3: Every CALL writes one record word into the current map window at register index fill+1, so records go to registers 1 to 15 in order. The word carries the old previous-window id in bits 31:26 and the return address in bits 25:0.
- R4: A CALL that finds the map window holding 15 records first takes the lowest free window as the new map window. It writes that window's register 0 with bits 31:16 all ones and bits 15:0 holding the older map id zero-extended, and then stores the record at register 1 of the new map window.
- R5: A RETURN frees the current window, moves the previous id into `cur_win`, loads `old_win` from bits 31:26 of the popped record, and presents bits 25:0 on `ret_ra` with `ret_ra_valid` and `cmd_done` high for one cycle.
- R6: A RETURN that finds the map window empty while older records exist reads register 0 of the map window, frees the map window, and makes the map id in bits 15:0 of that word current with 15 records. It then pops the record as in R5.
- R7: A RETURN with no recorded callers pulses `ret_underflow` for one cycle. `cur_win`, `old_win` and `map_win` stay unchanged, and no `cmd_done` follows.
- R8: When a window is needed and none is free, `spill_req` rises and stays high, with `req_ready` low, until `spill_ack`. The window named on `spill_win` then returns to the pool and the stalled CALL completes with it.
- R9: When `call_valid` and `ret_valid` are both high while the controller is ready, only the CALL is carried out.
- R10: A window freed by a RETURN is handed out again by the next CALL when it is the lowest free id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_valid | input | 1 | CALL request, taken when `req_ready` is high |
| call_ra | input | 26 | Return address stored with the CALL |
| ret_valid | input | 1 | RETURN request, taken when `req_ready` is high |
| req_ready | output | 1 | Controller idle and accepting a command |
| cmd_done | output | 1 | One-cycle pulse when a CALL or RETURN completes |
| cur_win | output | 6 | Current (callee) window id |
| old_win | output | 6 | Previous (caller) window id |
| map_win | output | 6 | Newest map window id |
| ret_ra | output | 26 | Return address popped by the last RETURN |
| ret_ra_valid | output | 1 | `ret_ra` valid, pulses with `cmd_done` on a RETURN |
| ret_underflow | output | 1 | One-cycle pulse on a RETURN with no recorded caller |
| rf_we | output | 1 | Register-file write enable |
| rf_wwin | output | 6 | Window id of the write |
| rf_wreg | output | 4 | Register index within the window for the write |
| rf_wdata | output | 32 | Write data (record or link word) |
| rf_re | output | 1 | Register-file read enable |
| rf_rwin | output | 6 | Window id of the read |
| rf_rreg | output | 4 | Register index of the read |
| rf_rdata | input | 32 | Read data, valid the cycle after `rf_re` |
| spill_req | output | 1 | No free window; spill needed |
| spill_ack | input | 1 | Spill done |
| spill_win | input | 6 | Window id freed by the spill, sampled with `spill_ack` |

## Verification
The assertions check on every cycle how the pool and the sequencer hand off to each other. A lone allocation removes exactly one id from the bitmap, and a released id is free afterwards. The window made current on a return is the one that was previous, and a completed call puts the former current id in the previous slot. A link write is always followed by that window becoming the map window. A spill request only rises with the pool empty and stays up until acknowledged. An underflow never disturbs the window ids. What the assertions cannot show is end-to-end correctness of the stack in memory: the right return address coming back after a map-window crossing, records landing at the right indexes, the link word format, lowest-id reuse after frees, and the spill hand-off. The bench shows these through its call/return scenarios against a reference stack and pool.

// File: rtl/winstk_pkg.sv
package winstk_pkg;

  localparam int ID_W   = 6;
  localparam int RA_W   = 26;
  localparam int WORD_W = ID_W + RA_W;
  localparam int REG_W  = 4;
  localparam int LINK_W = WORD_W / 2;
  localparam int RECS_PER_MAP = (1 << REG_W) - 1;

  typedef logic [ID_W-1:0]   win_id_t;
  typedef logic [RA_W-1:0]   ra_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [REG_W-1:0]  reg_idx_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALL,
    ST_SPILL,
    ST_LNK_RD,
    ST_LNK_WB,
    ST_RET_RD,
    ST_RET_WB
  } seq_st_e;

  // caller record: window id above, return address below
  function automatic word_t pack_rec(win_id_t id, ra_t ra);
    return {id, ra};
  endfunction

  function automatic win_id_t rec_id(word_t w);
    return w[WORD_W-1 -: ID_W];
  endfunction

  function automatic ra_t rec_ra(word_t w);
    return w[RA_W-1:0];
  endfunction

  // link word: newer link unknown (all ones), older map id below
  function automatic word_t pack_link(win_id_t prev);
    return {{LINK_W{1'b1}}, {(LINK_W-ID_W){1'b0}}, prev};
  endfunction

  function automatic win_id_t link_prev(word_t w);
    return w[ID_W-1:0];
  endfunction

endpackage

// File: rtl/winstk_pool.sv
module winstk_pool #(
  parameter int NWIN = 64,
  parameter int RESV = 2,
  localparam int IDW = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_en,
  input  logic           rel_en,
  input  logic [IDW-1:0] rel_id,
  output logic           any_free,
  output logic [IDW-1:0] pick_id
);

  localparam logic [NWIN-1:0] FREE_INIT = {NWIN{1'b1}} << RESV;

  logic [NWIN-1:0] free_q, free_d;

  // lowest-numbered free id wins
  always_comb begin
    pick_id = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (free_q[i]) pick_id = IDW'(i);
    end
    any_free = |free_q;
  end

  always_comb begin
    free_d = free_q;
    if (rel_en)   free_d[rel_id]  = 1'b1;
    if (alloc_en) free_d[pick_id] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= FREE_INIT;
    else        free_q <= free_d;
  end

  assert_alloc_needs_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> any_free);

  assert_alloc_takes_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !rel_en) |=> ($countones(free_q) == $past($countones(free_q)) - 1));

  assert_release_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !alloc_en) |=> free_q[$past(rel_id)]);

endmodule

// File: rtl/winstk_seq.sv
module winstk_seq
  import winstk_pkg::*;
#(
  parameter int MAX_RECS = 4096,
  parameter int MAP0     = 1,
  localparam int CW = $clog2(MAX_RECS + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     call_valid,
  input  ra_t      call_ra,
  input  logic     ret_valid,
  output logic     req_ready,
  output logic     cmd_done,
  output win_id_t  cur_win,
  output win_id_t  old_win,
  output win_id_t  map_win,
  output ra_t      ret_ra,
  output logic     ret_ra_valid,
  output logic     ret_underflow,
  output logic     rf_we,
  output win_id_t  rf_wwin,
  output reg_idx_t rf_wreg,
  output word_t    rf_wdata,
  output logic     rf_re,
  output win_id_t  rf_rwin,
  output reg_idx_t rf_rreg,
  input  word_t    rf_rdata,
  output logic     spill_req,
  input  logic     spill_ack,
  input  win_id_t  spill_win,
  input  logic     any_free,
  input  win_id_t  pick_id,
  output logic     alloc_en,
  output logic     rel_en,
  output win_id_t  rel_id
);

  localparam reg_idx_t FULL = reg_idx_t'(RECS_PER_MAP);

  seq_st_e  st_q, st_d;
  win_id_t  cur_q, old_q, map_q;
  reg_idx_t fill_q;
  logic [CW-1:0] cnt_q;
  ra_t      ra_q, ret_ra_q;
  logic     done_q, rv_q, err_q;

  // named events used by the assertions
  logic map_full, stack_empty, call_take;
  assign map_full    = (fill_q == FULL);
  assign stack_empty = (cnt_q == '0);
  assign call_take   = (st_q == ST_IDLE) && call_valid;

  always_comb begin
    st_d     = st_q;
    alloc_en = 1'b0;
    rel_en   = 1'b0;
    rel_id   = cur_q;
    rf_we    = 1'b0;
    rf_wwin  = map_q;
    rf_wreg  = fill_q + reg_idx_t'(1);
    rf_wdata = pack_rec(old_q, ra_q);
    rf_re    = 1'b0;
    rf_rwin  = map_q;
    rf_rreg  = fill_q;
    unique case (st_q)
      ST_IDLE: begin
        if (call_valid) st_d = ST_CALL;
        else if (ret_valid && !stack_empty)
          st_d = (fill_q == '0) ? ST_LNK_RD : ST_RET_RD;
      end
      ST_CALL: begin
        if (!any_free) st_d = ST_SPILL;
        else begin
          alloc_en = 1'b1;
          rf_we    = 1'b1;
          if (map_full) begin
            rf_wwin  = pick_id;
            rf_wreg  = '0;
            rf_wdata = pack_link(map_q);
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_SPILL: begin
        if (spill_ack) begin
          rel_en = 1'b1;
          rel_id = spill_win;
          st_d   = ST_CALL;
        end
      end
      ST_LNK_RD: begin
        rf_re   = 1'b1;
        rf_rreg = '0;
        st_d    = ST_LNK_WB;
      end
      ST_LNK_WB: begin
        rel_en = 1'b1;
        rel_id = map_q;
        st_d   = ST_RET_RD;
      end
      ST_RET_RD: begin
        rf_re = 1'b1;
        st_d  = ST_RET_WB;
      end
      ST_RET_WB: begin
        rel_en = 1'b1;
        rel_id = cur_q;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      old_q    <= '0;
      map_q    <= win_id_t'(MAP0);
      fill_q   <= '0;
      cnt_q    <= '0;
      ra_q     <= '0;
      ret_ra_q <= '0;
      done_q   <= 1'b0;
      rv_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      err_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (call_valid) ra_q <= call_ra;
          else if (ret_valid && stack_empty) err_q <= 1'b1;
        end
        ST_CALL: begin
          if (any_free) begin
            if (map_full) begin
              map_q  <= pick_id;
              fill_q <= '0;
            end else begin
              old_q  <= cur_q;
              cur_q  <= pick_id;
              fill_q <= fill_q + reg_idx_t'(1);
              cnt_q  <= cnt_q + CW'(1);
              done_q <= 1'b1;
            end
          end
        end
        ST_LNK_WB: begin
          map_q  <= link_prev(rf_rdata);
          fill_q <= FULL;
        end
        ST_RET_WB: begin
          cur_q    <= old_q;
          old_q    <= rec_id(rf_rdata);
          ret_ra_q <= rec_ra(rf_rdata);
          fill_q   <= fill_q - reg_idx_t'(1);
          cnt_q    <= cnt_q - CW'(1);
          done_q   <= 1'b1;
          rv_q     <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign spill_req     = (st_q == ST_SPILL);
  assign cmd_done      = done_q;
  assign ret_ra_valid  = rv_q;
  assign ret_underflow = err_q;
  assign cur_win       = cur_q;
  assign old_win       = old_q;
  assign map_win       = map_q;
  assign ret_ra        = ret_ra_q;

  assert_call_shifts_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !ret_ra_valid) |-> (old_win == $past(cur_win)));

  assert_link_then_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_wreg == '0) |=> (map_win == $past(rf_wwin)));

  assert_ret_restores_cur_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ra_valid |-> (cur_win == $past(old_win) && cmd_done));

  assert_underflow_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_underflow |-> ($stable(cur_win) && $stable(old_win) && $stable(map_win) && !cmd_done));

  assert_spill_only_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spill_req) |-> !any_free);

  assert_spill_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_req && !spill_ack) |=> (spill_req && !req_ready));

  assert_call_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (call_take && ret_valid) |=> !rf_re);

endmodule

// File: rtl/winstk_ctrl.sv
module winstk_ctrl
  import winstk_pkg::*;
#(
  parameter int NWIN     = 64,
  parameter int MAX_RECS = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        call_valid,
  input  logic [25:0] call_ra,
  input  logic        ret_valid,
  output logic        req_ready,
  output logic        cmd_done,
  output logic [5:0]  cur_win,
  output logic [5:0]  old_win,
  output logic [5:0]  map_win,
  output logic [25:0] ret_ra,
  output logic        ret_ra_valid,
  output logic        ret_underflow,
  output logic        rf_we,
  output logic [5:0]  rf_wwin,
  output logic [3:0]  rf_wreg,
  output logic [31:0] rf_wdata,
  output logic        rf_re,
  output logic [5:0]  rf_rwin,
  output logic [3:0]  rf_rreg,
  input  logic [31:0] rf_rdata,
  output logic        spill_req,
  input  logic        spill_ack,
  input  logic [5:0]  spill_win
);

  // windows 0 (first current) and 1 (first map) are taken at reset
  localparam int RESV = 2;
  localparam int MAP0 = 1;

  logic    any_free, alloc_en, rel_en;
  win_id_t pick_id, rel_id;

  winstk_pool #(
    .NWIN (NWIN),
    .RESV (RESV)
  ) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (alloc_en),
    .rel_en   (rel_en),
    .rel_id   (rel_id),
    .any_free (any_free),
    .pick_id  (pick_id)
  );

  winstk_seq #(
    .MAX_RECS (MAX_RECS),
    .MAP0     (MAP0)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .call_valid    (call_valid),
    .call_ra       (call_ra),
    .ret_valid     (ret_valid),
    .req_ready     (req_ready),
    .cmd_done      (cmd_done),
    .cur_win       (cur_win),
    .old_win       (old_win),
    .map_win       (map_win),
    .ret_ra        (ret_ra),
    .ret_ra_valid  (ret_ra_valid),
    .ret_underflow (ret_underflow),
    .rf_we         (rf_we),
    .rf_wwin       (rf_wwin),
    .rf_wreg       (rf_wreg),
    .rf_wdata      (rf_wdata),
    .rf_re         (rf_re),
    .rf_rwin       (rf_rwin),
    .rf_rreg       (rf_rreg),
    .rf_rdata      (rf_rdata),
    .spill_req     (spill_req),
    .spill_ack     (spill_ack),
    .spill_win     (spill_win),
    .any_free      (any_free),
    .pick_id       (pick_id),
    .alloc_en      (alloc_en),
    .rel_en        (rel_en),
    .rel_id        (rel_id)
  );

endmodule

// File: tb/winstk_ctrl_bench.sv
`timescale 1ns/1ps
module winstk_ctrl_bench;

  localparam int SPILL_ID = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_valid = 1'b0;
  logic [25:0] call_ra = '0;
  logic        ret_valid = 1'b0;
  logic        req_ready, cmd_done, ret_ra_valid, ret_underflow;
  logic [5:0]  cur_win, old_win, map_win;
  logic [25:0] ret_ra;
  logic        rf_we, rf_re;
  logic [5:0]  rf_wwin, rf_rwin;
  logic [3:0]  rf_wreg, rf_rreg;
  logic [31:0] rf_wdata;
  logic [31:0] rf_rdata = '0;
  logic        spill_req;
  logic        spill_ack = 1'b0;
  logic [5:0]  spill_win = '0;

  always #2 clk = ~clk;

  winstk_ctrl u_winstk_ctrl (.*);

  // register file model: write at the edge, read data one cycle later
  logic [31:0] rfm [64][16];
  always @(posedge clk) begin
    if (rf_we) rfm[rf_wwin][rf_wreg] <= rf_wdata;
    if (rf_re) rf_rdata <= rfm[rf_rwin][rf_rreg];
  end

  // reference model
  bit mfree [64];
  int mcur, mold, mmap, mfill;
  int stk_id[$], stk_ra[$], mapstk[$];
  bit spill_pend;

  typedef struct {
    int kind;   // 0 call, 1 return, 2 underflow
    int cur;
    int old;
    int map;
    int ra;
  } exp_t;
  exp_t expq[$];

  int nvec = 0, nbad = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int m_alloc();
    for (int i = 0; i < 64; i++) begin
      if (mfree[i]) begin
        mfree[i] = 1'b0;
        return i;
      end
    end
    spill_pend = 1'b1;   // agent frees SPILL_ID, which is then taken at once
    return SPILL_ID;
  endfunction

  // monitor: compare completions with the scoreboard
  always @(negedge clk) begin
    if (rst_n && (cmd_done || ret_underflow)) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        string rq;
        e = expq.pop_front();
        rq = (e.kind == 0) ? "R2" : (e.kind == 1) ? "R5" : "R7";
        chk(ret_underflow == (e.kind == 2), rq, "underflow flag", int'(ret_underflow), int'(e.kind == 2));
        chk(ret_ra_valid == (e.kind == 1), rq, "ret_ra_valid", int'(ret_ra_valid), int'(e.kind == 1));
        chk(int'(cur_win) == e.cur, rq, "cur_win", int'(cur_win), e.cur);
        chk(int'(old_win) == e.old, rq, "old_win", int'(old_win), e.old);
        chk(int'(map_win) == e.map, (e.kind == 0) ? "R4" : "R6", "map_win", int'(map_win), e.map);
        if (e.kind == 1) chk(int'(ret_ra) == e.ra, "R5", "ret_ra", int'(ret_ra), e.ra);
      end
    end
  end

  task automatic model_call(int ra);
    exp_t e;
    int nid;
    if (mfill == 15) begin
      mapstk.push_back(mmap);
      mmap  = m_alloc();
      mfill = 0;
    end
    nid = m_alloc();
    stk_id.push_back(mold);
    stk_ra.push_back(ra);
    mold = mcur;
    mcur = nid;
    mfill++;
    e = '{0, mcur, mold, mmap, 0};
    expq.push_back(e);
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic handle_spill();
    int n = 0;
    while (!spill_req && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(spill_req, "R8", "spill_req raised", int'(spill_req), 1);
    chk(!req_ready, "R8", "ready low in spill", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk(spill_req, "R8", "spill_req held", int'(spill_req), 1);
    chk(!req_ready, "R8", "ready held low", int'(req_ready), 0);
    spill_ack = 1'b1;
    spill_win = 6'(SPILL_ID);
    @(negedge clk);
    spill_ack = 1'b0;
    chk(!spill_req, "R8", "spill_req dropped after ack", int'(spill_req), 0);
  endtask

  task automatic do_call(int ra);
    @(negedge clk);
    wait_ready();
    model_call(ra);
    call_valid = 1'b1;
    call_ra    = 26'(ra);
    @(negedge clk);
    call_valid = 1'b0;
    if (spill_pend) begin
      spill_pend = 1'b0;
      handle_spill();
    end
    wait_ready();
  endtask

  task automatic do_ret();
    exp_t e;
    @(negedge clk);
    wait_ready();
    if (stk_id.size() == 0) begin
      e = '{2, mcur, mold, mmap, 0};
    end else begin
      int rid, rra;
      if (mfill == 0) begin
        mfree[mmap] = 1'b1;
        mmap  = mapstk.pop_back();
        mfill = 15;
      end
      rid = stk_id.pop_back();
      rra = stk_ra.pop_back();
      mfree[mcur] = 1'b1;
      mcur = mold;
      mold = rid;
      mfill--;
      e = '{1, mcur, mold, mmap, rra};
    end
    expq.push_back(e);
    ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
    @(negedge clk);
    wait_ready();
  endtask

  task automatic do_both(int ra);
    @(negedge clk);
    wait_ready();
    model_call(ra);
    call_valid = 1'b1;
    ret_valid  = 1'b1;
    call_ra    = 26'(ra);
    @(negedge clk);
    call_valid = 1'b0;
    ret_valid  = 1'b0;
    wait_ready();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mfree[i] = (i >= 2);
    mcur = 0; mold = 0; mmap = 1; mfill = 0; spill_pend = 1'b0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cur_win == 0, "R1", "cur_win", int'(cur_win), 0);
    chk(old_win == 0, "R1", "old_win", int'(old_win), 0);
    chk(map_win == 1, "R1", "map_win", int'(map_win), 1);
    chk(req_ready, "R1", "req_ready", int'(req_ready), 1);
    chk(!spill_req && !cmd_done && !ret_ra_valid && !ret_underflow, "R1", "idle flags", 1, 0);

    // R7 underflow on an empty stack
    do_ret();

    // R2 and R5 basic call and return
    do_call(26'h0000ABC);
    do_call(26'h3FFFFFF);
    do_ret();
    do_ret();
    do_ret();

    // R10 freed window is reused
    do_call(26'h0000123);
    chk(cur_win == 2, "R10", "reused id", int'(cur_win), 2);
    do_ret();
    do_call(26'h0000456);
    chk(cur_win == 2, "R10", "reused id again", int'(cur_win), 2);
    do_ret();

    // R3 and R4 sixteen calls cross into a second map window
    for (int i = 0; i < 16; i++) do_call(26'h100000 + i * 37);
    repeat (2) @(negedge clk);
    for (int k = 1; k <= 15; k++) begin
      logic [31:0] w;
      w = {6'(stk_id[k-1]), 26'(stk_ra[k-1])};
      chk(rfm[1][k] == w, "R3", "record word", int'(rfm[1][k]), int'(w));
    end
    chk(rfm[mmap][0] == {16'hFFFF, 16'd1}, "R4", "link word", int'(rfm[mmap][0]), int'({16'hFFFF, 16'd1}));
    chk(rfm[mmap][1] == {6'(stk_id[15]), 26'(stk_ra[15])}, "R4", "first record in new map",
        int'(rfm[mmap][1]), int'({6'(stk_id[15]), 26'(stk_ra[15])}));

    // R6 unwind through the map boundary
    for (int i = 0; i < 16; i++) do_ret();
    chk(map_win == 1, "R6", "map after unwind", int'(map_win), 1);

    // R9 call wins over return
    do_both(26'h0ACE123);
    do_ret();
    do_ret();

    // R8 exhaust the pool: 59 calls drain it, the 60th spills
    for (int i = 0; i < 60; i++) do_call(26'h200000 + i * 101);
    for (int i = 0; i < 60; i++) do_ret();
    do_ret();

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2", "scoreboard drained", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule